// File: doc/BRIEF.md
# Dual-Pipeline Frame Start Address Registers

This block holds the frame-buffer start address that each of two display pipelines uses. Software reaches it through an index/data pair. It writes an index with the port address bit at 0, then reads or writes the selected byte with the bit at 1. Three indexed bytes make up the address: a low byte, a high byte and an extended byte. The extended byte carries the top four address bits and a commit request bit. A pipeline-select input decides which pipeline's copy a data access touches.

In standard mode the block forwards the 16-bit address made of the high and low bytes directly, and the top four bits read as zero. In extended mode the 20 address bits are staged in a pending copy. The active address changes only when that pipeline's vertical sync rises while its commit request is set. The block then clears the request, so software can poll for completion. Each pipeline commits on its own sync.

Top module: `scanbase_regs`

## Requirements
- R1: A write with `bus_addr`=0 loads the index. A write with `bus_addr`=1 stores `bus_wdata` into the register named by the index, in the copy chosen by `pipe_sel` (0 = A, 1 = B). A read with `bus_addr`=1 returns that register, and a read with `bus_addr`=0 returns the index. The index codes are 0Ch for the high byte, 0Dh for the low byte and 40h for the extended byte. Other indices read 0, and writes to them change nothing.
- R2: With `ext_mode`=0, a pipeline's base output equals {4'h0, high byte, low byte}. It follows a byte write on the first clock edge after the data write.
- R3: In the extended byte, bit 7 is the commit request and bits 3:0 are address bits 19:16. Both read back as written until hardware changes them.
- R4: With `ext_mode`=1, writes to the low, high or extended byte never change a base output.
- R5: With `ext_mode`=1, a clock edge where the pipeline's `vsync` bit is 1 is a rising sync if that bit was 0 at the previous edge. If the request is set at that edge, the base becomes {bits 3:0, high, low} of the staged bytes.
- R6: A rising sync with the request clear leaves the base output unchanged.
- R7: The commit clears the request bit, so the extended byte then reads with bit 7 at 0.
- R8: Bits 6:4 of the extended byte always read 0 whatever was written. After reset, every register, the index and both base outputs are 0.
- R9: The two pipelines are independent. A sync on one pipeline never commits the other, and a data write touches only the copy chosen by `pipe_sel`.
- R10: With `ext_mode`=0, a rising sync neither commits nor clears a pending request. On return to `ext_mode`=1, the base shows the last committed address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 1 | 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one clock per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port chosen by `bus_addr` |
| pipe_sel | input | 1 | Pipeline copy for data accesses (0 = A, 1 = B) |
| ext_mode | input | 1 | 0 = standard 16-bit mode, 1 = staged 20-bit mode |
| vsync | input | 2 | Vertical sync level, bit 0 for pipeline A, bit 1 for pipeline B |
| base_a | output | 20 | Active start address of pipeline A |
| base_b | output | 20 | Active start address of pipeline B |

## Verification
The bench sweeps every value of the top nibble on both pipelines. Each value is staged with the reserved bits set, and the bench confirms that the base holds through a sync without a request and through a sync on the other pipeline. A design that committed at every sync, or that routed syncs to the wrong pipeline, would change the base too early. A design that never cleared the request would read back bit 7 still set. The bench also requests a commit in standard mode and then returns to extended mode. A design that ignored the mode in its commit logic would consume the request there and show the wrong address afterwards.

// File: rtl/scanbase_pkg.sv
package scanbase_pkg;
  localparam int DW = 8;
  localparam logic [DW-1:0] IDX_HI  = 8'h0C;
  localparam logic [DW-1:0] IDX_LO  = 8'h0D;
  localparam logic [DW-1:0] IDX_EXT = 8'h40;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_EXT  = 2'd3
  } regsel_e;

  function automatic regsel_e decode_idx(input logic [DW-1:0] idx);
    regsel_e s;
    case (idx)
      IDX_LO:  s = SEL_LO;
      IDX_HI:  s = SEL_HI;
      IDX_EXT: s = SEL_EXT;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction
endpackage

// File: rtl/sb_edge.sv
module sb_edge #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] lvl_q;
  logic [W-1:0] lvl_d;

  always_comb begin
    lvl_d = lvl;
    rise  = lvl & ~lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_d;
  end
endmodule

// File: rtl/sb_port.sv
module sb_port
  import scanbase_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] idx,
  output regsel_e       sel,
  output logic          data_wr
);
  logic [DW-1:0] idx_q;
  logic [DW-1:0] idx_d;
  logic          idx_en;

  always_comb begin
    idx_en  = bus_wr && !bus_addr;
    idx_d   = bus_wdata;
    data_wr = bus_wr && bus_addr;
    sel     = decode_idx(idx_q);
    idx     = idx_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end
endmodule

// File: rtl/sb_pipe.sv
module sb_pipe
  import scanbase_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  regsel_e       sel,
  input  logic [DW-1:0] wdata,
  input  logic          vs_rise,
  input  logic          ext_mode,
  output logic [DW-1:0] rd_byte,
  output logic [AW-1:0] base,
  output logic [AW-1:0] pend,
  output logic          arm
);
  localparam int HW  = AW - 2 * DW;
  localparam int RSV = DW - 1 - HW;

  logic [DW-1:0] lo_q, lo_d, hi_q, hi_d;
  logic [HW-1:0] nib_q, nib_d;
  logic          arm_q, arm_d;
  logic [AW-1:0] act_q, act_d;
  logic          commit;
  logic          unused_rsv;

  always_comb begin
    lo_d   = lo_q;
    hi_d   = hi_q;
    nib_d  = nib_q;
    arm_d  = arm_q;
    commit = vs_rise && arm_q && ext_mode;
    pend   = {nib_q, hi_q, lo_q};
    act_d  = act_q;
    if (commit) begin
      act_d = pend;
      arm_d = 1'b0;
    end
    if (wr_en) begin
      case (sel)
        SEL_LO:  lo_d = wdata;
        SEL_HI:  hi_d = wdata;
        SEL_EXT: begin
          nib_d = wdata[HW-1:0];
          arm_d = wdata[DW-1];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      nib_q <= '0;
      arm_q <= 1'b0;
      act_q <= '0;
    end else begin
      lo_q  <= lo_d;
      hi_q  <= hi_d;
      nib_q <= nib_d;
      arm_q <= arm_d;
      act_q <= act_d;
    end
  end

  always_comb begin
    unused_rsv = ^wdata[DW-2:HW];
    arm        = arm_q;
    base       = ext_mode ? act_q : {{HW{1'b0}}, hi_q, lo_q};
    case (sel)
      SEL_LO:  rd_byte = lo_q;
      SEL_HI:  rd_byte = hi_q;
      SEL_EXT: rd_byte = {arm_q, {RSV{1'b0}}, nib_q};
      default: rd_byte = '0;
    endcase
  end
endmodule

// File: rtl/scanbase_regs.sv
module scanbase_regs
  import scanbase_pkg::*;
#(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_addr,
  input  logic          bus_wr,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  input  logic          pipe_sel,
  input  logic          ext_mode,
  input  logic [1:0]    vsync,
  output logic [AW-1:0] base_a,
  output logic [AW-1:0] base_b
);
  localparam int NP = 2;

  logic [DW-1:0]         idx_q;
  regsel_e               sel;
  logic                  data_wr;
  logic [NP-1:0]         vs_rise;
  logic [NP-1:0]         arm_w;
  logic [NP-1:0]         wr_ext_w;
  logic [NP-1:0][DW-1:0] rd_w;
  logic [NP-1:0][AW-1:0] base_w;
  logic [NP-1:0][AW-1:0] pend_w;

  sb_port u_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .idx(idx_q), .sel(sel), .data_wr(data_wr)
  );

  sb_edge #(.W(NP)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(vsync), .rise(vs_rise)
  );

  for (genvar g = 0; g < NP; g++) begin : g_pipe
    logic wr_here;
    assign wr_here     = data_wr && (pipe_sel == g[0]);
    assign wr_ext_w[g] = wr_here && (sel == SEL_EXT);
    sb_pipe #(.AW(AW)) u_pipe (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_here), .sel(sel),
      .wdata(bus_wdata), .vs_rise(vs_rise[g]), .ext_mode(ext_mode),
      .rd_byte(rd_w[g]), .base(base_w[g]), .pend(pend_w[g]), .arm(arm_w[g])
    );
  end

  always_comb begin
    bus_rdata = bus_addr ? rd_w[pipe_sel] : idx_q;
    base_a    = base_w[0];
    base_b    = base_w[1];
  end
endmodule

// File: rtl/scanbase_chk.sv
module scanbase_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ext_mode,
  input logic          bus_addr,
  input logic [7:0]    bus_rdata,
  input logic [7:0]    idx,
  input logic [1:0]    vs_rise,
  input logic [1:0]    arm,
  input logic [1:0]    wr_ext,
  input logic [AW-1:0] pend_a,
  input logic [AW-1:0] base_a,
  input logic [AW-1:0] base_b
);
  AST_STD_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> (base_a[AW-1:16] == '0 && base_b[AW-1:16] == '0)); // R2
  AST_HOLD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !vs_rise[0]) |=> (!ext_mode || $stable(base_a))); // R4
  AST_HOLD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && !vs_rise[1]) |=> (!ext_mode || $stable(base_b))); // R9
  AST_COMMIT_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && vs_rise[0] && arm[0]) |=> (!ext_mode || base_a == $past(pend_a))); // R5
  AST_NO_ARM_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && vs_rise[0] && !arm[0]) |=> (!ext_mode || $stable(base_a))); // R6
  AST_ARM_CLEAR_A: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && vs_rise[0] && arm[0] && !wr_ext[0]) |=> !arm[0]); // R7
  AST_ARM_KEEP_STD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_mode && arm[0] && !wr_ext[0]) |=> arm[0]); // R10
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr && idx == 8'h40) |-> bus_rdata[6:4] == 3'b000); // R8
endmodule

bind scanbase_regs scanbase_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .idx(idx_q), .vs_rise(vs_rise), .arm(arm_w),
  .wr_ext(wr_ext_w), .pend_a(pend_w[0]), .base_a(base_a), .base_b(base_b)
);

// File: tb/scanbase_regs_tb_top.sv
module scanbase_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_addr = 1'b0, bus_wr = 1'b0, pipe_sel = 1'b0, ext_mode = 1'b0;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [1:0]  vsync = 2'b00;
  logic [19:0] base_a, base_b;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  logic [7:0]  m_lo [2];
  logic [7:0]  m_hi [2];
  logic [3:0]  m_nib[2];
  logic        m_arm[2];
  logic [19:0] m_act[2];

  always #10 clk = ~clk;

  scanbase_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pipe_sel(pipe_sel),
    .ext_mode(ext_mode), .vsync(vsync), .base_a(base_a), .base_b(base_b)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk); pipe_sel = p[0]; bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = idx;
    @(negedge clk); bus_addr = 1'b1; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input int p, input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk); pipe_sel = p[0]; bus_addr = 1'b0; bus_wr = 1'b1; bus_wdata = idx;
    @(negedge clk); bus_wr = 1'b0; bus_addr = 1'b1;
    #1 d = bus_rdata;
  endtask

  task automatic sync(input int p);
    @(negedge clk); vsync[p] = 1'b1;
    @(negedge clk); vsync[p] = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [19:0] exp_base(input int p);
    if (ext_mode) return m_act[p];
    return {4'h0, m_hi[p], m_lo[p]};
  endfunction

  task automatic chk_bases(input string req);
    chk(base_a == exp_base(0), {req, " base_a"}, base_a, exp_base(0));
    chk(base_b == exp_base(1), {req, " base_b"}, base_b, exp_base(1));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    for (int p = 0; p < 2; p++) begin
      m_lo[p] = '0; m_hi[p] = '0; m_nib[p] = '0; m_arm[p] = 1'b0; m_act[p] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk_bases("R8 reset");
    for (int p = 0; p < 2; p++) begin
      rd(p, 8'h0C, d); chk(d == 8'h00, "R8 reset hi", d, 0);
      rd(p, 8'h0D, d); chk(d == 8'h00, "R8 reset lo", d, 0);
      rd(p, 8'h40, d); chk(d == 8'h00, "R8 reset ext", d, 0);
    end
    @(negedge clk); bus_addr = 1'b0; #1;
    chk(bus_rdata == 8'h40, "R1 index readback", bus_rdata, 8'h40);

    // R2 standard mode sweep, R1 readback, R9 copy steering
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 8; k++) begin
        m_hi[p] = 8'((k * 37 + p * 5 + 1) & 255);
        m_lo[p] = 8'((k * 91 + p * 13 + 3) & 255);
        wr(p, 8'h0C, m_hi[p]);
        wr(p, 8'h0D, m_lo[p]);
        chk_bases("R2 std follow");
        rd(p, 8'h0C, d); chk(d == m_hi[p], "R1 hi readback", d, m_hi[p]);
        rd(p, 8'h0D, d); chk(d == m_lo[p], "R1 lo readback", d, m_lo[p]);
        rd(1 - p, 8'h0D, d); chk(d == m_lo[1-p], "R9 other copy", d, m_lo[1-p]);
      end
    end
    wr(0, 8'h41, 8'hFF);
    rd(0, 8'h41, d); chk(d == 8'h00, "R1 unknown index", d, 0);
    rd(0, 8'h40, d); chk(d == 8'h00, "R1 unknown write ignored", d, 0);
    chk_bases("R1 unknown write ignored");

    // extended mode sweep
    @(negedge clk); ext_mode = 1'b1;
    @(negedge clk);
    chk_bases("R10 enter ext");
    for (int p = 0; p < 2; p++) begin
      for (int n = 0; n < 16; n++) begin
        m_lo[p]  = 8'((n * 17 + p * 29 + 7) & 255);
        m_hi[p]  = 8'((n * 53 + p * 3 + 11) & 255);
        m_nib[p] = 4'(n);
        wr(p, 8'h0D, m_lo[p]);
        wr(p, 8'h0C, m_hi[p]);
        wr(p, 8'h40, {4'b0111, m_nib[p]});
        chk_bases("R4 staged write");
        rd(p, 8'h40, d); chk(d == {4'h0, m_nib[p]}, "R8 reserved read zero", d, {4'h0, m_nib[p]});
        sync(p);
        chk_bases("R6 sync without request");
        wr(p, 8'h40, {4'h8, m_nib[p]});
        m_arm[p] = 1'b1;
        rd(p, 8'h40, d); chk(d == {4'h8, m_nib[p]}, "R3 request readback", d, {4'h8, m_nib[p]});
        chk_bases("R4 request write");
        sync(1 - p);
        chk_bases("R9 other sync");
        sync(p);
        m_act[p] = {m_nib[p], m_hi[p], m_lo[p]};
        m_arm[p] = 1'b0;
        chk_bases("R5 commit");
        rd(p, 8'h40, d); chk(d == {4'h0, m_nib[p]}, "R7 request cleared", d, {4'h0, m_nib[p]});
      end
    end

    // R10 standard mode keeps the request
    m_hi[0] = 8'hA5; m_lo[0] = 8'h3C; m_nib[0] = 4'h9;
    wr(0, 8'h0C, m_hi[0]); wr(0, 8'h0D, m_lo[0]);
    wr(0, 8'h40, 8'h89);
    @(negedge clk); ext_mode = 1'b0;
    @(negedge clk);
    chk_bases("R10 std shows staged");
    sync(0);
    rd(0, 8'h40, d); chk(d == 8'h89, "R10 request kept in std", d, 8'h89);
    @(negedge clk); ext_mode = 1'b1;
    @(negedge clk);
    chk_bases("R10 last committed");
    sync(0);
    m_act[0] = {m_nib[0], m_hi[0], m_lo[0]};
    chk_bases("R5 late commit");
    rd(0, 8'h40, d); chk(d == 8'h09, "R7 late clear", d, 8'h09);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule